// File: doc/BRIEF.md
# Sequential Signed Multiplier with Run-Length Recoding

This block multiplies two signed two's-complement operands of `N` bits each (default 32) and returns their exact `2N`-bit signed product. It spends one clock cycle per multiplier bit. In each cycle it looks at the lowest bit of a working register together with one extra bit held below it. From that pair it adds the multiplicand to the upper half, subtracts it, or leaves the upper half alone. It then shifts the whole register, extra bit included, one place to the right while copying the sign bit.

A client raises `start` for one cycle with both operands valid while `busy` is low. The block latches the operands and raises `busy`. After `N` steps it pulses `done` for one cycle. `product` carries the new result from that cycle on, and it keeps that value until the next result is ready.

The controller is a three-state machine:
- `ST_IDLE`: waiting for `start`.
- `ST_RUN`: one recode, add-or-subtract and shift step per cycle.
- `ST_FIN`: the single `done` cycle.

Its transitions are:
- `ST_IDLE -> ST_RUN` when `start` is sampled high (the load transition).
- `ST_RUN -> ST_RUN` while the step counter is below `N-1` (the step transition).
- `ST_RUN -> ST_FIN` on the last step (the finish transition).
- `ST_FIN -> ST_IDLE` unconditionally (the release transition).

Top module: `booth_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low latches `mcand_i` and `mplier_i`, and `busy` is 1 in the following cycle.
- R3: A `start` sampled while `busy` is high, including during the `done` cycle, has no effect: the result reported is that of the latched operands, and `busy` is 0 in the cycle after the `done` cycle.
- R4: `done` is 1 for exactly one cycle. That cycle begins at the `N`-th rising edge after the edge that accepted `start`. `busy` is 1 from the accepting edge through the `done` cycle.
- R5: When `done` is 1, `product` equals the signed product of the latched operands as `2N` bits, for every operand pair, including the most negative value on either or both inputs.
- R6: `product` changes only at the edge that begins a `done` cycle. It holds its previous value while idle and throughout the next computation.
- R7: The step action is chosen from the pair (lowest register bit, extra bit) as follows: 10 subtracts the multiplicand, 01 adds it, and 00 and 11 leave the upper half unchanged. With N=4, 0010 times 0110 gives 0000_1100, and 0010 times 1101 gives 1111_1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication (accepted only while idle) |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product of the last finished operation |

## Verification
The edge that samples `start` is taken as edge 0. `busy` is due just after edge 0. `done` and the new `product` are due just after edge `N`, and `busy` falls just after edge `N+1`. The bench drives inputs on falling edges and samples at the falling edge after each rising edge. It counts exactly `N` rising edges before it expects `done`, and it checks that `done` is low at every earlier sample point. A bound checker tracks the same `N`-edge window with its own counter and flags any change of `product` outside a `done` cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_t;

endpackage

// File: rtl/booth_recode.sv
// Run-length recoding of the (current bit, previous bit) pair.
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0] pair,   // [1] = low register bit, [0] = extra bit
    output op_t        op
);
    always_comb begin
        op = OP_NONE;
        unique case (pair)
            2'b10:   op = OP_SUB;   // a run of ones begins
            2'b01:   op = OP_ADD;   // a run of ones has ended
            default: op = OP_NONE;  // inside a run of zeros or of ones
        endcase
    end
endmodule

// File: rtl/booth_step.sv
// One iteration: add or subtract on N+1 bits, then arithmetic shift right.
module booth_step
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] upper,   // upper half of the working register
    input  logic [N-1:0] lower,   // lower half (multiplier bits still to scan)
    input  logic [N-1:0] mcand,
    input  op_t          op,
    output logic [2*N:0] next_acc
);
    localparam int EW = N + 1;

    logic [EW-1:0] up_ext;
    logic [EW-1:0] mc_ext;
    logic [EW-1:0] sum;

    assign up_ext = {upper[N-1], upper};
    assign mc_ext = {mcand[N-1], mcand};

    always_comb begin
        sum = up_ext;
        unique case (op)
            OP_ADD:  sum = up_ext + mc_ext;
            OP_SUB:  sum = up_ext - mc_ext;
            default: sum = up_ext;
        endcase
    end

    // The extra top bit of sum is the true sign and fills in on the shift.
    assign next_acc = {sum, lower};
endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: idle, N step cycles, one done cycle.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int            CW       = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

    state_t        st;
    state_t        st_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_CNT);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_RUN;
            ST_RUN:  if (last)  st_nx = ST_FIN;
            ST_FIN:             st_nx = ST_IDLE;
            default:            st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (st)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIN: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N-1:0]     mcand_i,
    input  logic [N-1:0]     mplier_i,
    output logic             busy,
    output logic             done,
    output logic [2*N-1:0]   product
);
    localparam int AW = 2 * N + 1;

    logic            load;
    logic            step;
    logic            last;
    logic [AW-1:0]   acc;        // {upper, lower, extra}
    logic [AW-1:0]   acc_nx;
    logic [N-1:0]    mcand_q;
    logic [2*N-1:0]  prod_q;
    op_t             op;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .pair (acc[1:0]),
        .op   (op)
    );

    booth_step #(.N(N)) u_step (
        .upper    (acc[2*N:N+1]),
        .lower    (acc[N:1]),
        .mcand    (mcand_q),
        .op       (op),
        .next_acc (acc_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= {{N{1'b0}}, mplier_i, 1'b0};
            mcand_q <= mcand_i;
        end else if (step) begin
            acc     <= acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            prod_q <= '0;
        else if (step && last) prod_q <= acc_nx[AW-1:1];
    end

    assign product = prod_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int            CW   = $clog2(N + 2);
    localparam logic [CW-1:0] CMAX = CW'(N + 1);
    localparam logic [CW-1:0] CEND = CW'(N);

    logic [CW-1:0] edges;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           edges <= '0;
        else if (start && !busy)              edges <= '0;
        else if (busy && edges != CMAX)       edges <= edges + 1'b1;
    end

    // R1: reset clears the handshake outputs
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R2: an accepted start raises busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done falls inside the busy window
    p_done_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R4: done arrives N edges after the accepting edge
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edges == CEND));

    // R3: after the done cycle the block is idle again, whatever start was
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: the result changes only at the start of a done cycle
    p_prod_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product) |-> done);
endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
    localparam int TB_N     = 4;
    localparam int CLK_HALF = 5;
    localparam int WD_LIMIT = 150000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [TB_N-1:0]     mcand_i = '0;
    logic [TB_N-1:0]     mplier_i = '0;
    logic                busy;
    logic                done;
    logic [2*TB_N-1:0]   product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    booth_mul #(.N(TB_N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*TB_N-1:0] ref_mul(input logic [TB_N-1:0] a,
                                                 input logic [TB_N-1:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[2*TB_N-1:0];
    endfunction

    // Runs one operation from idle; checks timing, busy and result.
    task automatic run_op(input logic [TB_N-1:0] a, input logic [TB_N-1:0] b,
                          input string req);
        bit timing_ok = 1'b1;
        logic [2*TB_N-1:0] exp = ref_mul(a, b);
        @(negedge clk);
        mcand_i = a;
        mplier_i = b;
        start = 1'b1;
        @(posedge clk);               // edge 0: accepted
        @(negedge clk);
        start = 1'b0;
        if (!busy) timing_ok = 1'b0;  // R2
        for (int i = 1; i <= TB_N; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done != (i == TB_N)) timing_ok = 1'b0;
            if (!busy) timing_ok = 1'b0;
        end
        check(timing_ok, "R4", "done/busy window", longint'(done), 1);
        check(product == exp, req, $sformatf("%0d*%0d", $signed(a), $signed(b)),
              longint'(product), longint'(exp));
        @(posedge clk);
        @(negedge clk);
        check(!busy && !done, "R4", "busy released", longint'({busy, done}), 0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*TB_N-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1", "in reset",
              longint'({busy, done, product}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1", "after release",
              longint'({busy, done, product}), 0);

        // R7: recoding examples
        run_op(4'b0010, 4'b0110, "R7");
        run_op(4'b0010, 4'b1101, "R7");

        // R5: exhaustive sweep, most negative included
        for (int a = 0; a < (1 << TB_N); a++) begin
            for (int b = 0; b < (1 << TB_N); b++) begin
                run_op(TB_N'(a), TB_N'(b), "R5");
            end
        end

        // R6: result holds while idle and during the next run
        run_op(4'b0011, 4'b1011, "R5");
        held = product;
        repeat (4) @(negedge clk);
        check(product == held, "R6", "idle hold", longint'(product), longint'(held));
        mcand_i = 4'b0111;
        mplier_i = 4'b0111;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (TB_N - 1) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(product == held && !done, "R6", "hold during run",
              longint'(product), longint'(held));
        @(posedge clk);
        @(negedge clk);
        check(done && product == 8'd49, "R6", "new result at done",
              longint'(product), 49);
        @(posedge clk);
        @(negedge clk);

        // R3: start held high through busy and done with other operands
        mcand_i = 4'b0101;
        mplier_i = 4'b1110;
        start = 1'b1;
        @(posedge clk);               // accepted: 5 * -2
        @(negedge clk);
        mcand_i = 4'b1000;
        mplier_i = 4'b1000;
        for (int i = 1; i <= TB_N; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(done && product == ref_mul(4'b0101, 4'b1110), "R3",
              "start ignored while running", longint'(product),
              longint'(ref_mul(4'b0101, 4'b1110)));
        @(posedge clk);               // FIN edge with start still high
        @(negedge clk);
        check(!busy, "R3", "start ignored in done cycle", longint'(busy), 0);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!busy && product == ref_mul(4'b0101, 4'b1110), "R3",
              "no extra operation", longint'(product),
              longint'(ref_mul(4'b0101, 4'b1110)));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule